// File: doc/BRIEF.md
# Byte-Accessed 16-bit Up-Counter with Atomic Load and Read

This block is a 16-bit up-counting timer that a byte-wide processor programs and reads through a small register port. Each access is one address, one write or read strobe and one data byte. The counter advances on ticks from one of eight sources. Seven of the sources are fixed fractions of the system clock. The eighth counts rising edges on an external event pin, after that pin passes through a synchronizer.

Software sees each 16-bit quantity as two bytes. Writing the upper byte only parks it in a buffer. Writing the lower byte afterwards commits both halves to the reload register and to the counter in the same cycle. Reading works the other way round: reading the lower count byte snapshots the upper byte, so the next upper-byte read returns a value that matches the lower byte already read, even if the counter has moved since.

When the counter passes its maximum it reloads from the committed reload value and raises a sticky overflow flag. An interrupt line reports that flag when the enable bit allows it. A narrow mode confines counting to the lower byte and leaves the upper byte untouched.

Top module: `byte_timer16`

## Requirements
- R1: A write to address 3 (reload upper byte) only fills an internal buffer. The committed reload value and the counter stay unchanged until the next lower-byte write.
- R2: A write to address 2 (reload lower byte) loads `{buffer, data}` into both the reload register and the counter in the same cycle. If the bytes are written low first and then high, the committed value still holds the earlier upper byte. Reads of address 2 and 3 return the committed reload bytes.
- R3: A read of address 4 returns count bits 7:0 and copies count bits 15:8 into a read snapshot. A read of address 5 returns that snapshot, even if the counter has changed since.
- R4: The control register (address 0) holds: bit 0 run, bit 1 wide (1 = 16-bit mode), bits 4:2 source select, bit 7 interrupt enable. Source codes 0 to 6 advance the count once every 1, 2, 4, 8, 16, 64 or 512 system clocks. Any write to the control register restarts the prescaler phase, so with divide d the count reaches floor(D/d) D cycles after the write.
- R5: Source code 7 advances the count once for each rising edge of `event_i`, after a two-stage synchronizer. While code 7 is selected, the system clock alone does not move the count.
- R6: In wide mode, a tick at count 0xFFFF loads the committed reload value. Every overflow sets the flag in status bit 0 (address 1), whatever the interrupt enable.
- R7: `irq_o` is high exactly when the overflow flag and the interrupt enable are both set.
- R8: Writing a 1 to status bit 0 clears the flag. If an overflow occurs in the same cycle as the clear, the flag ends up set.
- R9: In narrow mode (wide = 0), only bits 7:0 count. They pass from 0xFF to reload bits 7:0 and set the flag, and count bits 15:8 do not change.
- R10: While run is 0, the count holds its value.
- R11: After reset, every register reads 0 and `irq_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 3 | Register address |
| wr_en_i | input | 1 | Write strobe, one cycle per byte |
| rd_en_i | input | 1 | Read strobe, one cycle per byte |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, valid while `rd_en_i` is high |
| event_i | input | 1 | External count event, asynchronous |
| irq_o | output | 1 | Overflow interrupt request |

## Verification
The properties assume that a write strobe and a read strobe are never high in the same cycle, and that the address is stable for the whole of each strobe cycle. The bus tasks in the stimulus drive exactly one strobe, for exactly one cycle, with the address set up from the first edge. The event input is held high and then low for four clocks at a time, so each level passes through the synchronizer and each pulse gives exactly one tick.

// File: rtl/byte_timer16_pkg.sv
package byte_timer16_pkg;

  localparam int unsigned ADDR_W = 3;
  localparam int unsigned DATA_W = 8;
  localparam int unsigned CNT_W  = 2 * DATA_W;
  localparam int unsigned SEL_W  = 3;
  localparam int unsigned NUM_SRC = 1 << SEL_W;

  typedef enum logic [ADDR_W-1:0] {
    A_CTRL   = 3'd0,
    A_STAT   = 3'd1,
    A_RLD_LO = 3'd2,
    A_RLD_HI = 3'd3,
    A_CNT_LO = 3'd4,
    A_CNT_HI = 3'd5
  } reg_addr_e;

  localparam logic [SEL_W-1:0] SRC_EVENT = 3'd7;

  // log2 of the clock divide ratio for each source code
  function automatic int unsigned div_shift(input int unsigned code);
    case (code)
      0: return 0;
      1: return 1;
      2: return 2;
      3: return 3;
      4: return 4;
      5: return 6;
      6: return 9;
      default: return 0;
    endcase
  endfunction

  localparam int unsigned PRE_W = div_shift(6);

endpackage

// File: rtl/byte_timer16_tick.sv
module byte_timer16_tick
  import byte_timer16_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             restart_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic             event_i,
  output logic             tick_o
);

  localparam int unsigned SH_W = SYNC_STAGES + 1;

  logic [PRE_W-1:0]   pre_q;
  logic [SH_W-1:0]    evt_q;
  logic [NUM_SRC-1:0] src_tick;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        pre_q <= '0;
    else if (restart_i) pre_q <= '0;
    else                pre_q <= pre_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) evt_q <= '0;
    else         evt_q <= {evt_q[SH_W-2:0], event_i};
  end

  for (genvar g = 0; g < NUM_SRC - 1; g++) begin : g_div
    localparam int unsigned SH = div_shift(g);
    if (SH == 0) begin : g_full
      assign src_tick[g] = 1'b1;
    end else begin : g_part
      assign src_tick[g] = &pre_q[SH-1:0];
    end
  end

  // rising edge of the synchronized event
  assign src_tick[NUM_SRC-1] = evt_q[SH_W-2] & ~evt_q[SH_W-1];

  assign tick_o = src_tick[sel_i];

endmodule

// File: rtl/byte_timer16_count.sv
module byte_timer16_count #(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic [W-1:0] reload_i,
  input  logic         tick_i,
  input  logic         wide_i,
  output logic [W-1:0] count_o,
  output logic         ovf_o
);

  localparam int unsigned HALF = W / 2;

  logic [W-1:0] cnt_q;
  logic         at_top;

  assign at_top  = wide_i ? (&cnt_q) : (&cnt_q[HALF-1:0]);
  assign ovf_o   = tick_i & ~load_i & at_top;
  assign count_o = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (load_i) begin
      cnt_q <= load_val_i;
    end else if (tick_i) begin
      if (wide_i) begin
        cnt_q <= at_top ? reload_i : cnt_q + 1'b1;
      end else begin
        cnt_q[HALF-1:0] <= at_top ? reload_i[HALF-1:0] : cnt_q[HALF-1:0] + 1'b1;
      end
    end
  end

endmodule

// File: rtl/byte_timer16.sv
module byte_timer16
  import byte_timer16_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              event_i,
  output logic              irq_o
);

  logic              run_q, wide_q, ie_q, flag_q;
  logic [SEL_W-1:0]  src_q;
  logic [DATA_W-1:0] hi_buf_q, rd_shadow_q;
  logic [CNT_W-1:0]  reload_q, count_q;
  logic              wr_ctrl, wr_stat, wr_lo, wr_hi, rd_cnt_lo;
  logic              src_tick, ovf;

  assign wr_ctrl   = wr_en_i && (addr_i == A_CTRL);
  assign wr_stat   = wr_en_i && (addr_i == A_STAT);
  assign wr_lo     = wr_en_i && (addr_i == A_RLD_LO);
  assign wr_hi     = wr_en_i && (addr_i == A_RLD_HI);
  assign rd_cnt_lo = rd_en_i && (addr_i == A_CNT_LO);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q  <= 1'b0;
      wide_q <= 1'b0;
      src_q  <= '0;
      ie_q   <= 1'b0;
    end else if (wr_ctrl) begin
      run_q  <= wdata_i[0];
      wide_q <= wdata_i[1];
      src_q  <= wdata_i[4:2];
      ie_q   <= wdata_i[7];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    hi_buf_q <= '0;
    else if (wr_hi) hi_buf_q <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    reload_q <= '0;
    else if (wr_lo) reload_q <= {hi_buf_q, wdata_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        rd_shadow_q <= '0;
    else if (rd_cnt_lo) rd_shadow_q <= count_q[CNT_W-1:DATA_W];
  end

  // a new overflow wins over a clear in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     flag_q <= 1'b0;
    else if (ovf)                    flag_q <= 1'b1;
    else if (wr_stat && wdata_i[0])  flag_q <= 1'b0;
  end

  byte_timer16_tick u_tick (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .restart_i (wr_ctrl),
    .sel_i     (src_q),
    .event_i   (event_i),
    .tick_o    (src_tick)
  );

  byte_timer16_count #(.W(CNT_W)) u_count (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (wr_lo),
    .load_val_i ({hi_buf_q, wdata_i}),
    .reload_i   (reload_q),
    .tick_i     (src_tick & run_q),
    .wide_i     (wide_q),
    .count_o    (count_q),
    .ovf_o      (ovf)
  );

  always_comb begin
    rdata_o = '0;
    if (rd_en_i) begin
      case (addr_i)
        A_CTRL:   rdata_o = {ie_q, 2'b00, src_q, wide_q, run_q};
        A_STAT:   rdata_o = {{(DATA_W-1){1'b0}}, flag_q};
        A_RLD_LO: rdata_o = reload_q[DATA_W-1:0];
        A_RLD_HI: rdata_o = reload_q[CNT_W-1:DATA_W];
        A_CNT_LO: rdata_o = count_q[DATA_W-1:0];
        A_CNT_HI: rdata_o = rd_shadow_q;
        default:  rdata_o = '0;
      endcase
    end
  end

  assign irq_o = flag_q & ie_q;

endmodule

// File: rtl/byte_timer16_chk.sv
module byte_timer16_chk
  import byte_timer16_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] addr_i,
  input logic              wr_en_i,
  input logic              rd_en_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic              irq_o,
  input logic              run_q,
  input logic              wide_q,
  input logic              ie_q,
  input logic              flag_q,
  input logic              ovf,
  input logic [DATA_W-1:0] hi_buf_q,
  input logic [DATA_W-1:0] rd_shadow_q,
  input logic [CNT_W-1:0]  reload_q,
  input logic [CNT_W-1:0]  count_q
);

  p_hi_write_holds_reload_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == A_RLD_HI) |=> $stable(reload_q));

  p_lo_write_commits_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == A_RLD_LO) |=>
      (reload_q == {$past(hi_buf_q), $past(wdata_i)}) && (count_q == reload_q));

  p_shadow_holds_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rd_en_i && addr_i == A_CNT_LO) |=> $stable(rd_shadow_q));

  p_ovf_sets_flag_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf |=> flag_q);

  p_irq_needs_enable_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ie_q |-> !irq_o);

  p_narrow_upper_frozen_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wide_q && !(wr_en_i && addr_i == A_RLD_LO)) |=> $stable(count_q[CNT_W-1:DATA_W]));

  p_stopped_holds_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_q && !(wr_en_i && addr_i == A_RLD_LO)) |=> $stable(count_q));

endmodule

bind byte_timer16 byte_timer16_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .addr_i      (addr_i),
  .wr_en_i     (wr_en_i),
  .rd_en_i     (rd_en_i),
  .wdata_i     (wdata_i),
  .irq_o       (irq_o),
  .run_q       (run_q),
  .wide_q      (wide_q),
  .ie_q        (ie_q),
  .flag_q      (flag_q),
  .ovf         (ovf),
  .hi_buf_q    (hi_buf_q),
  .rd_shadow_q (rd_shadow_q),
  .reload_q    (reload_q),
  .count_q     (count_q)
);

// File: tb/byte_timer16_test.sv
module byte_timer16_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] addr = '0;
  logic       wr_en = 1'b0, rd_en = 1'b0, evt = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       irq;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 1'b0;

  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #5 clk = ~clk;

  byte_timer16 uut (
    .clk_i   (clk),
    .rst_ni  (rst_n),
    .addr_i  (addr),
    .wr_en_i (wr_en),
    .rd_en_i (rd_en),
    .wdata_i (wdata),
    .rdata_o (rdata),
    .event_i (evt),
    .irq_o   (irq)
  );

  // monitor: pops one expected item per read strobe
  always @(negedge clk) begin
    if (rd_en) begin
      logic [7:0] e;
      string t;
      if (exp_q.size() == 0) begin
        n_vec++; n_bad++;
        $display("FAIL scoreboard: read with no expected item, actual %02h", rdata);
      end else begin
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        n_vec++;
        if (rdata !== e) begin
          n_bad++;
          $display("FAIL %s: actual %02h expected %02h", t, rdata, e);
        end
      end
    end
  end

  task automatic bus_wr(input logic [2:0] a, input logic [7:0] d);
    @(posedge clk); #1 addr = a; wdata = d; wr_en = 1'b1;
    @(posedge clk); #1 wr_en = 1'b0;
  endtask

  task automatic bus_rd(input logic [2:0] a, input logic [7:0] e, input string t);
    @(posedge clk); #1 addr = a; rd_en = 1'b1;
    exp_q.push_back(e); tag_q.push_back(t);
    @(posedge clk); #1 rd_en = 1'b0;
  endtask

  task automatic load16(input logic [7:0] hi, input logic [7:0] lo);
    bus_wr(3'd3, hi);
    bus_wr(3'd2, lo);
  endtask

  task automatic chk_irq(input logic e, input string t);
    @(negedge clk);
    n_vec++;
    if (irq !== e) begin
      n_bad++;
      $display("FAIL %s: irq actual %0b expected %0b", t, irq, e);
    end
  endtask

  task automatic pulse_evt();
    @(posedge clk); #1 evt = 1'b1;
    repeat (4) @(posedge clk);
    #1 evt = 1'b0;
    repeat (4) @(posedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not finish, actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R11 reset state
    bus_rd(3'd0, 8'h00, "R11 ctrl");
    bus_rd(3'd1, 8'h00, "R11 status");
    bus_rd(3'd2, 8'h00, "R11 reload lo");
    bus_rd(3'd4, 8'h00, "R11 count lo");
    chk_irq(1'b0, "R11 irq");

    // R2 ordered load
    load16(8'h12, 8'h34);
    bus_rd(3'd2, 8'h34, "R2 reload lo");
    bus_rd(3'd3, 8'h12, "R2 reload hi");
    bus_rd(3'd4, 8'h34, "R2 count lo");
    bus_rd(3'd5, 8'h12, "R2 count hi");

    // R1 upper byte alone changes nothing
    bus_wr(3'd3, 8'h77);
    bus_rd(3'd3, 8'h12, "R1 reload hi unchanged");
    bus_rd(3'd4, 8'h34, "R1 count lo unchanged");
    bus_rd(3'd5, 8'h12, "R1 count hi unchanged");
    bus_wr(3'd2, 8'h56);
    bus_rd(3'd3, 8'h77, "R2 buffered hi commits");
    bus_rd(3'd2, 8'h56, "R2 lo commits");

    // R2 wrong order: low then high
    bus_wr(3'd2, 8'h78);
    bus_wr(3'd3, 8'h56);
    bus_rd(3'd2, 8'h78, "R2 wrong order lo");
    bus_rd(3'd3, 8'h77, "R2 wrong order keeps old hi");

    // R4 divide ratios, wide mode, stop after D cycles
    for (int k = 0; k < 7; k++) begin
      int d;
      int dd;
      d  = (k < 5) ? (1 << k) : ((k == 5) ? 64 : 512);
      dd = 3 * d + d / 2;
      bus_wr(3'd0, 8'h02);
      load16(8'h00, 8'h00);
      bus_wr(3'd0, 8'((k << 2) | 3));
      repeat (dd - 2) @(posedge clk);
      bus_wr(3'd0, 8'h02);
      bus_rd(3'd4, 8'h03, $sformatf("R4 divide %0d count lo", d));
      bus_rd(3'd5, 8'h00, $sformatf("R4 divide %0d count hi", d));
    end

    // R10 stopped counter holds
    repeat (20) @(posedge clk);
    bus_rd(3'd4, 8'h03, "R10 stopped count lo");

    // R6 wide overflow reloads, flag without enable; R7 gating
    bus_wr(3'd1, 8'h01);
    load16(8'hFF, 8'hFD);
    bus_wr(3'd0, 8'h03);
    repeat (2) @(posedge clk);
    bus_wr(3'd0, 8'h02);
    bus_rd(3'd4, 8'hFE, "R6 reload after wrap lo");
    bus_rd(3'd5, 8'hFF, "R6 reload after wrap hi");
    bus_rd(3'd1, 8'h01, "R6 flag set with irq disabled");
    chk_irq(1'b0, "R7 irq masked");
    bus_wr(3'd0, 8'h82);
    chk_irq(1'b1, "R7 irq enabled");

    // R8 clear
    bus_wr(3'd1, 8'h01);
    chk_irq(1'b0, "R8 irq after clear");
    bus_rd(3'd1, 8'h00, "R8 flag cleared");
    bus_wr(3'd1, 8'h00);
    bus_rd(3'd1, 8'h00, "R8 zero write no effect");

    // R8 overflow coincides with clear
    bus_wr(3'd0, 8'h02);
    load16(8'hFF, 8'hFD);
    bus_wr(3'd0, 8'h03);
    repeat (1) @(posedge clk);
    bus_wr(3'd1, 8'h01);
    bus_wr(3'd0, 8'h02);
    bus_rd(3'd1, 8'h01, "R8 overflow beats clear");

    // R9 narrow mode
    bus_wr(3'd1, 8'h01);
    bus_wr(3'd0, 8'h00);
    load16(8'h5A, 8'hFD);
    bus_wr(3'd0, 8'h01);
    repeat (2) @(posedge clk);
    bus_wr(3'd0, 8'h00);
    bus_rd(3'd4, 8'hFE, "R9 narrow lo wrapped");
    bus_rd(3'd5, 8'h5A, "R9 narrow hi frozen");
    bus_rd(3'd1, 8'h01, "R9 narrow flag");

    // R5 event source, R3 read snapshot
    bus_wr(3'd0, 8'h00);
    load16(8'h12, 8'hFF);
    bus_wr(3'd0, 8'h1F);
    repeat (6) @(posedge clk);
    bus_rd(3'd4, 8'hFF, "R5 no count without events");
    pulse_evt();
    bus_rd(3'd5, 8'h12, "R3 snapshot held");
    bus_rd(3'd4, 8'h00, "R5 one event lo");
    bus_rd(3'd5, 8'h13, "R3 new snapshot");
    pulse_evt();
    pulse_evt();
    bus_rd(3'd4, 8'h02, "R5 two more events");
    bus_rd(3'd0, 8'h1F, "R4 ctrl readback");

    repeat (4) @(posedge clk);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule